// File: doc/BRIEF.md
# One-Shot ADC Channel Sequencer

This block drives an external successive-approximation converter core in a single software-triggered mode. Software picks one of four analog channels, writes the operating fields, and sets an enable bit. The block then asks the converter for exactly one conversion of that channel. When the code comes back, it stores the code in the result register that belongs to that channel alone, drops its busy indication, and signals completion with a one-cycle interrupt pulse. It then stays idle until software arms it again.

The converter is reached through a start pulse, a channel index, a done pulse and a 10-bit code bus. Software sees a small register space on a simple write port and a combinational read port. The control register holds the operating fields, and these are accepted only when they describe the supported mode. Each channel has a private result register, so a code taken from one channel never overwrites another channel's result.

Top module: `oneshot_adc_seq`

## Requirements
- R1: After reset, every readable register (control at address 0, channel select at address 1, results at addresses 4 to 7) reads zero, and `cnv_start` and `eoc_irq` are low.
- R2: The control register has these fields: bits [1:0] hold the mode, bit 2 the trigger select, bit 3 the buffer select, bit 6 the busy flag (read only) and bit 7 the enable. The channel select sits in bits [2:0] of address 1. Writing control with bit 7 = 1, mode = 2'b10, trigger = 0 and buffer = 0, while idle and with a select value below 4, makes `cnv_start` high for exactly one cycle. That cycle directly follows the write edge. In it `cnv_chan` equals the select value, and bits 7 and 6 of control read 1.
- R3: The code on `cnv_code` in the cycle `cnv_done` is high during a conversion is stored in the result register of the converted channel, at address 4 plus the channel index. It is readable from the following cycle.
- R4: The result registers of channels other than the converted one keep their previous values.
- R5: From the edge that samples `cnv_done` during a conversion, `eoc_irq` is high for exactly one cycle, and control bits 7 and 6 read 0.
- R6: Each enable write yields at most one conversion. No further `cnv_start` appears until software writes the enable bit again, and a new enable write starts a new conversion.
- R7: While a conversion is in progress, writes to the control and channel select registers change no field, start nothing, and leave `cnv_chan` unchanged.
- R8: An enable write whose mode, trigger or buffer fields differ from 2'b10, 0, 0, or made while the select holds 4 to 7, starts no conversion and raises no interrupt. The written mode, trigger and buffer fields are still stored.
- R9: A `cnv_done` pulse while idle changes no result register and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cnv_start | output | 1 | One-cycle conversion request to the converter core |
| cnv_chan | output | 2 | Channel index for the converter core |
| cnv_done | input | 1 | Conversion finished pulse from the converter core |
| cnv_code | input | 10 | Conversion code, valid when `cnv_done` is high |
| eoc_irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
A wrong state bit in the sequencer shows up on the next clock. A busy flag stuck high or low changes bits 7 and 6 of the control read at once, and it also suppresses or duplicates a `cnv_start` within a cycle of the enable write. A wrong latched channel shows up as a wrong `cnv_chan` in the start cycle and as a code landing at the wrong result address one cycle after `cnv_done`. A behavioural model in the bench tracks the busy state, the stored fields and all four results. It compares the start, channel, interrupt and read data on every cycle, so such a fault is caught in the cycle where it first reaches a port.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // control register field positions
    localparam int MODE_LSB  = 0;
    localparam int TRIG_BIT  = 2;
    localparam int BUF_BIT   = 3;
    localparam int BUSY_BIT  = 6;
    localparam int EN_BIT    = 7;

    // register addresses
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_SEL  = 1;
    localparam int RES_BASE  = 4;

    // the only supported operating point
    localparam logic [1:0] MODE_SELECT = 2'b10;

    typedef struct packed {
        logic [1:0] mode;
        logic       trig;
        logic       bufsel;
    } ctrl_fields_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_t;

endpackage

// File: rtl/adcseq_cfg.sv
module adcseq_cfg
    import adcseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int SEL_W  = 3,
    parameter int CH_N   = 4,
    localparam int CH_W  = $clog2(CH_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output ctrl_fields_t      fields,
    output logic [SEL_W-1:0]  sel,
    output logic              go,
    output logic [CH_W-1:0]   go_chan
);

    typedef struct packed {
        ctrl_fields_t      f;
        logic [SEL_W-1:0]  sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ctrl, wr_sel, supported, sel_ok;
    logic unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        cfg_d     = cfg_q;
        wr_ctrl   = wr_en && !busy && (int'(wr_addr) == ADDR_CTRL);
        wr_sel    = wr_en && !busy && (int'(wr_addr) == ADDR_SEL);
        supported = (wr_data[MODE_LSB +: 2] == MODE_SELECT)
                    && !wr_data[TRIG_BIT] && !wr_data[BUF_BIT];
        sel_ok    = int'(cfg_q.sel) < CH_N;
        if (wr_ctrl) begin
            cfg_d.f.mode   = wr_data[MODE_LSB +: 2];
            cfg_d.f.trig   = wr_data[TRIG_BIT];
            cfg_d.f.bufsel = wr_data[BUF_BIT];
        end
        if (wr_sel) begin
            cfg_d.sel = wr_data[SEL_W-1:0];
        end
        go      = wr_ctrl && wr_data[EN_BIT] && supported && sel_ok;
        go_chan = cfg_q.sel[CH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fields = cfg_q.f;
    assign sel    = cfg_q.sel;

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int CH_N  = 4,
    parameter int RES_W = 10,
    localparam int CH_W = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CH_W-1:0]  go_chan,
    input  logic             cnv_done,
    input  logic [RES_W-1:0] cnv_code,
    output logic             busy,
    output logic             cnv_start,
    output logic [CH_W-1:0]  cnv_chan,
    output logic             eoc_irq,
    output logic             res_we,
    output logic [CH_W-1:0]  res_idx,
    output logic [RES_W-1:0] res_val
);

    typedef struct packed {
        seq_state_t       st;
        logic             start;
        logic             irq;
        logic [CH_W-1:0]  chan;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.irq   = 1'b0;
        res_we      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (go) begin
                    seq_d.st    = ST_CONV;
                    seq_d.start = 1'b1;
                    seq_d.chan  = go_chan;
                end
            end
            ST_CONV: begin
                if (cnv_done) begin
                    res_we    = 1'b1;
                    seq_d.st  = ST_IDLE;
                    seq_d.irq = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, start: 1'b0, irq: 1'b0, chan: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.st == ST_CONV);
    assign cnv_start = seq_q.start;
    assign cnv_chan  = seq_q.chan;
    assign eoc_irq   = seq_q.irq;
    assign res_idx   = seq_q.chan;
    assign res_val   = cnv_code;

endmodule

// File: rtl/adcseq_results.sv
module adcseq_results #(
    parameter int CH_N  = 4,
    parameter int RES_W = 10,
    localparam int CH_W = $clog2(CH_N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [CH_W-1:0]            idx,
    input  logic [RES_W-1:0]           val,
    output logic [CH_N-1:0][RES_W-1:0] bank
);

    logic [CH_N-1:0][RES_W-1:0] bank_d, bank_q;

    for (genvar g = 0; g < CH_N; g++) begin : g_lane
        always_comb begin
            bank_d[g] = bank_q[g];
            if (we && (idx == CH_W'(g))) begin
                bank_d[g] = val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank = bank_q;

endmodule

// File: rtl/oneshot_adc_seq.sv
module oneshot_adc_seq
    import adcseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int RES_W  = 10,
    parameter int CH_N   = 4,
    parameter int SEL_W  = 3,
    localparam int CH_W  = $clog2(CH_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_chan,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_code,
    output logic              eoc_irq
);

    ctrl_fields_t               fields_w;
    logic [SEL_W-1:0]           sel_w;
    logic                       go_w;
    logic [CH_W-1:0]            go_chan_w;
    logic                       busy_w;
    logic                       res_we_w;
    logic [CH_W-1:0]            res_idx_w;
    logic [RES_W-1:0]           res_val_w;
    logic [CH_N-1:0][RES_W-1:0] bank_w;

    adcseq_cfg #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W),
        .CH_N   (CH_N)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy_w),
        .fields  (fields_w),
        .sel     (sel_w),
        .go      (go_w),
        .go_chan (go_chan_w)
    );

    adcseq_ctrl #(
        .CH_N  (CH_N),
        .RES_W (RES_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_w),
        .go_chan   (go_chan_w),
        .cnv_done  (cnv_done),
        .cnv_code  (cnv_code),
        .busy      (busy_w),
        .cnv_start (cnv_start),
        .cnv_chan  (cnv_chan),
        .eoc_irq   (eoc_irq),
        .res_we    (res_we_w),
        .res_idx   (res_idx_w),
        .res_val   (res_val_w)
    );

    adcseq_results #(
        .CH_N  (CH_N),
        .RES_W (RES_W)
    ) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (res_we_w),
        .idx   (res_idx_w),
        .val   (res_val_w),
        .bank  (bank_w)
    );

    // combinational register read
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == ADDR_CTRL) begin
            rd_data[MODE_LSB +: 2] = fields_w.mode;
            rd_data[TRIG_BIT]      = fields_w.trig;
            rd_data[BUF_BIT]       = fields_w.bufsel;
            rd_data[BUSY_BIT]      = busy_w;
            rd_data[EN_BIT]        = busy_w;
        end else if (int'(rd_addr) == ADDR_SEL) begin
            rd_data[SEL_W-1:0] = sel_w;
        end else begin
            for (int i = 0; i < CH_N; i++) begin
                if (int'(rd_addr) == RES_BASE + i) begin
                    rd_data = DATA_W'(bank_w[i]);
                end
            end
        end
    end

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cnv_start,
    input logic [CH_W-1:0] cnv_chan,
    input logic            cnv_done,
    input logic            eoc_irq,
    input logic            busy
);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start); // R2

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> (busy && !$past(busy))); // R6

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cnv_chan)); // R7

    AST_DONE_ENDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnv_done) |=> (eoc_irq && !busy)); // R5

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq); // R5

    AST_IRQ_NEEDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> ($past(busy) && $past(cnv_done))); // R9

endmodule

bind oneshot_adc_seq adcseq_checker #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_start (cnv_start),
    .cnv_chan  (cnv_chan),
    .cnv_done  (cnv_done),
    .eoc_irq   (eoc_irq),
    .busy      (busy_w)
);

// File: tb/test_oneshot_adc_seq.sv
module test_oneshot_adc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cnv_start;
    logic [1:0]  cnv_chan;
    logic        cnv_done = 1'b0;
    logic [9:0]  cnv_code = '0;
    logic        eoc_irq;

    int n_chk = 0;
    int n_bad = 0;
    int n_start = 0;
    int n_irq = 0;
    int cyc = 0;
    bit finished = 0;

    // behavioural reference state
    int m_mode, m_trig, m_buf, m_sel, m_busy, m_chan, m_start, m_irq;
    int m_res[4];

    always #5 clk = ~clk;

    oneshot_adc_seq i_oneshot_adc_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cnv_start (cnv_start),
        .cnv_chan  (cnv_chan),
        .cnv_done  (cnv_done),
        .cnv_code  (cnv_code),
        .eoc_irq   (eoc_irq)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int m_read(int a);
        if (a == 0) return m_mode | (m_trig << 2) | (m_buf << 3) | (m_busy << 6) | (m_busy << 7);
        if (a == 1) return m_sel;
        if (a >= 4) return m_res[a-4];
        return 0;
    endfunction

    // reference model, updated on every edge from the inputs held there
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_mode = 0; m_trig = 0; m_buf = 0; m_sel = 0;
            m_busy = 0; m_chan = 0; m_start = 0; m_irq = 0;
            foreach (m_res[k]) m_res[k] = 0;
        end else begin
            m_start = 0;
            m_irq = 0;
            if (m_busy != 0) begin
                if (cnv_done) begin
                    m_res[m_chan] = int'(cnv_code);
                    m_busy = 0;
                    m_irq = 1;
                end
            end else if (wr_en) begin
                if (wr_addr == 3'd0) begin
                    m_mode = int'(wr_data[1:0]);
                    m_trig = int'(wr_data[2]);
                    m_buf  = int'(wr_data[3]);
                    if (wr_data[7] && m_mode == 2 && m_trig == 0 && m_buf == 0 && m_sel < 4) begin
                        m_busy = 1;
                        m_start = 1;
                        m_chan = m_sel;
                    end
                end else if (wr_addr == 3'd1) begin
                    m_sel = int'(wr_data[2:0]);
                end
            end
        end
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_start += int'(cnv_start);
            n_irq   += int'(eoc_irq);
            chk("R2 model start", int'(cnv_start), m_start);
            chk("R5 model irq", int'(eoc_irq), m_irq);
            if (m_busy != 0) chk("R7 model chan", int'(cnv_chan), m_chan);
            if (rd_addr < 3'd4) chk("R7 model regs", int'(rd_data), m_read(int'(rd_addr)));
            else chk("R3 model result", int'(rd_data), m_read(int'(rd_addr)));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1;
        wr_addr = 3'(a);
        wr_data = 16'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic done_pulse(int code);
        cnv_done = 1'b1;
        cnv_code = 10'(code);
        step();
        cnv_done = 1'b0;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        rd_addr = 3'(a);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        int s0, i0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", a, 0);
        chk("R1 reset start", int'(cnv_start), 0);
        chk("R1 reset irq", int'(eoc_irq), 0);

        // R2 arm channel 2
        wr(1, 2);
        wr(0, 'h82);
        chk("R2 start pulse", int'(cnv_start), 1);
        chk("R2 channel out", int'(cnv_chan), 2);
        rd_chk("R2 busy read", 0, 'hC2);
        step();
        chk("R2 start single", int'(cnv_start), 0);
        step();
        done_pulse('h2A5);
        chk("R5 irq high", int'(eoc_irq), 1);
        rd_chk("R5 busy clear", 0, 'h02);
        rd_chk("R3 ch2 result", 6, 'h2A5);
        rd_chk("R4 ch0 kept", 4, 0);
        rd_chk("R4 ch1 kept", 5, 0);
        rd_chk("R4 ch3 kept", 7, 0);
        step();
        chk("R5 irq one cycle", int'(eoc_irq), 0);

        // R6 no restart without a new enable write, then re-arm
        s0 = n_start;
        repeat (10) step();
        chk("R6 no extra start", n_start - s0, 0);
        wr(1, 0);
        wr(0, 'h82);
        step();
        done_pulse('h3FF);
        rd_chk("R3 ch0 result", 4, 'h3FF);
        rd_chk("R4 ch2 kept", 6, 'h2A5);
        chk("R6 one start per arm", n_start - s0, 1);

        // R7 writes during a conversion
        wr(1, 1);
        wr(0, 'h82);
        step();
        s0 = n_start;
        wr(1, 3);
        wr(0, 'h03);
        wr(0, 'h82);
        rd_chk("R7 ctrl kept", 0, 'hC2);
        rd_chk("R7 sel kept", 1, 1);
        chk("R7 chan kept", int'(cnv_chan), 1);
        done_pulse('h155);
        rd_chk("R3 ch1 result", 5, 'h155);
        rd_chk("R4 ch3 still zero", 7, 0);
        step();
        chk("R7 no start while busy", n_start - s0, 0);

        // R8 unsupported settings
        s0 = n_start;
        i0 = n_irq;
        wr(0, 'h83);
        rd_chk("R8 mode stored", 0, 'h03);
        wr(0, 'h86);
        rd_chk("R8 trig stored", 0, 'h06);
        wr(0, 'h8A);
        rd_chk("R8 buf stored", 0, 'h0A);
        wr(1, 5);
        wr(0, 'h82);
        rd_chk("R8 bad sel idle", 0, 'h02);
        repeat (3) step();
        chk("R8 no start", n_start - s0, 0);
        chk("R8 no irq", n_irq - i0, 0);

        // R9 stray done while idle
        i0 = n_irq;
        done_pulse('h111);
        chk("R9 no irq", int'(eoc_irq), 0);
        rd_chk("R9 ch0 kept", 4, 'h3FF);
        rd_chk("R9 ch1 kept", 5, 'h155);
        rd_chk("R9 ch2 kept", 6, 'h2A5);
        rd_chk("R9 ch3 kept", 7, 0);
        step();
        chk("R9 irq count", n_irq - i0, 0);

        // R6 re-arm after rejected writes, channel 3
        wr(1, 3);
        wr(0, 'h82);
        chk("R6 rearm start", int'(cnv_start), 1);
        step();
        done_pulse('h0C3);
        rd_chk("R3 ch3 result", 7, 'h0C3);
        repeat (3) step();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule